// File: doc/BRIEF.md
# E3 Transmit Overhead Sequencer

This block assembles the transmit side of an E3 line frame from a serial payload stream. One clock period is one bit period. A free-running position counter walks the 1536 bit slots of a frame. The block marks the first slot with a one-clock boundary strobe. It holds an overhead flag high across the 12 leading slots, so the terminal equipment knows when its payload bits are not wanted.

In those 12 slots the serial output carries a fixed 10-bit alignment word, then an alarm bit, then a national-use bit. A 2-bit selector picks one of four places for the national-use bit to come from. In the remaining 1524 slots the payload input passes straight to the serial output.

The transmit bit clock is expected to be looped from the receive recovered clock, and it arrives on `clk`. An asynchronous active-low reset is synchronised inside the block. Once the reset is released, the first frame starts with the first alignment bit.

Top module: `e3_tx_ovh_seq`

## Requirements
- R1: While reset is asserted, `ser_out`, `ovh_ind` and `frame_pulse` are 0. Counting from the falling clock edge at which `rst_n` rises, the third rising edge starts the first frame, which begins in slot 0. Asserting `rst_n` low mid-frame forces all three outputs to 0 at once.
- R2: `frame_pulse` is high for exactly one clock per frame, in slot 0. Successive pulses are 1536 clocks apart.
- R3: `ovh_ind` is high in slots 0 to 11 and low in slots 12 to 1535, which gives exactly 12 consecutive clocks starting with the `frame_pulse` clock.
- R4: Slots 0 to 9 carry the alignment word 1111010000, most significant bit first (slot 0 = 1, slot 4 = 0, slot 5 = 1, slots 6 to 9 = 0).
- R5: Slot 10 carries the value of `alarm_in` sampled in the slot 0 clock. `alarm_in` in other slots has no effect on it.
- R6: With `n_src_sel` = 00, slot 11 carries `n_reg_bit`.
- R7: With `n_src_sel` = 01, slot 11 carries `ovh_data_in`.
- R8: With `n_src_sel` = 10, slot 11 carries `dl_n_bit`.
- R9: With `n_src_sel` = 11, slot 11 carries `payload_in` as presented in that clock.
- R10: In slots 12 to 1535, `ser_out` equals `payload_in` in the same clock. In slots 0 to 10, `payload_in` has no effect on `ser_out`, and in slot 11 it has none unless `n_src_sel` = 11. The three national-bit source inputs have no effect outside slot 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| n_src_sel | input | 2 | National-bit source: 00 register, 01 overhead input, 10 data-link bit, 11 payload |
| n_reg_bit | input | 1 | National bit held in a configuration register |
| ovh_data_in | input | 1 | National bit from the overhead data input |
| dl_n_bit | input | 1 | National bit from the data-link controller |
| alarm_in | input | 1 | Alarm indication, sampled in slot 0 |
| payload_in | input | 1 | Serial payload bit from the terminal |
| ser_out | output | 1 | Serial E3 frame output |
| ovh_ind | output | 1 | High during the 12 overhead slots |
| frame_pulse | output | 1 | One-clock strobe in the first slot of each frame |

## Verification
The assertions take for granted that `clk` runs without gaps. Each cycle is a bit period, so nothing but reset may stall the slot counter. They also assume `alarm_in` holds a known level in the slot 0 clock, which its ten-cycle look-back check depends on.

The stimulus changes every input only on falling edges, so the combinational serial output settles well before the rising edge that the assertions sample. Outside the slots where an input matters, the bench drives that input to the inverse of the expected output bit. Any leak of the input would therefore show up at `ser_out`.

// File: rtl/e3_ovh_pkg.sv
package e3_ovh_pkg;

  typedef enum logic [1:0] {
    NSRC_REG = 2'b00,
    NSRC_OVH = 2'b01,
    NSRC_DL  = 2'b10,
    NSRC_PAY = 2'b11
  } nsrc_e;

  typedef enum logic [1:0] {
    SLOT_ALIGN = 2'b00,
    SLOT_ALARM = 2'b01,
    SLOT_NAT   = 2'b10,
    SLOT_PAY   = 2'b11
  } slot_e;

endpackage

// File: rtl/e3_rst_sync.sv
module e3_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/e3_frame_counter.sv
module e3_frame_counter
  import e3_ovh_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int OVH_BITS   = 12,
  parameter int PAT_W      = 10,
  parameter int IDX_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             run,
  output logic [IDX_W-1:0] idx,
  output logic             frame_start,
  output logic             ovh_active,
  output slot_e            slot
);

  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] OVH_END   = IDX_W'(OVH_BITS);
  localparam logic [IDX_W-1:0] ALARM_IDX = IDX_W'(PAT_W);
  localparam logic [IDX_W-1:0] NAT_IDX   = IDX_W'(PAT_W + 1);

  logic             run_q, run_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             cnt_en;

  // next state
  always_comb begin
    run_d  = 1'b1;
    cnt_en = run_q;
    idx_d  = idx_q;
    if (cnt_en) begin
      if (idx_q == LAST_IDX) begin
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      idx_q <= '0;
    end else begin
      run_q <= run_d;
      idx_q <= idx_d;
    end
  end

  // slot decode
  always_comb begin
    if (idx_q < ALARM_IDX) begin
      slot = SLOT_ALIGN;
    end else if (idx_q == ALARM_IDX) begin
      slot = SLOT_ALARM;
    end else if (idx_q == NAT_IDX) begin
      slot = SLOT_NAT;
    end else begin
      slot = SLOT_PAY;
    end
  end

  assign run         = run_q;
  assign idx         = idx_q;
  assign frame_start = run_q && (idx_q == '0);
  assign ovh_active  = run_q && (idx_q < OVH_END);

  // checker state: length of the current overhead run
  logic [IDX_W-1:0] ovh_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovh_run_q <= '0;
    end else if (ovh_active) begin
      ovh_run_q <= ovh_run_q + 1'b1;
    end else begin
      ovh_run_q <= '0;
    end
  end

  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && idx_q == LAST_IDX) |=> frame_start);

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_ovh_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovh_active) |-> (ovh_run_q == OVH_END));

endmodule

// File: rtl/e3_ovh_mux.sv
module e3_ovh_mux
  import e3_ovh_pkg::*;
#(
  parameter int             PAT_W   = 10,
  parameter logic [PAT_W-1:0] PATTERN = 10'b1111010000,
  parameter int             IDX_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [IDX_W-1:0] idx,
  input  logic             frame_start,
  input  slot_e            slot,
  input  logic [1:0]       n_src_sel,
  input  logic             n_reg_bit,
  input  logic             ovh_data_in,
  input  logic             dl_n_bit,
  input  logic             alarm_in,
  input  logic             payload_in,
  output logic             ser_out
);

  logic             alarm_q, alarm_d;
  logic [IDX_W-1:0] pat_pos;
  logic [PAT_W-1:0] pat_shift;
  logic             align_bit;
  logic             nat_bit;

  // alarm capture, once per frame in slot 0
  always_comb begin
    alarm_d = alarm_q;
    if (frame_start) begin
      alarm_d = alarm_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
    end else begin
      alarm_q <= alarm_d;
    end
  end

  // alignment word, most significant bit first
  always_comb begin
    pat_pos   = IDX_W'(PAT_W - 1) - idx;
    pat_shift = PATTERN >> pat_pos;
    align_bit = pat_shift[0];
  end

  // national-bit source
  always_comb begin
    case (nsrc_e'(n_src_sel))
      NSRC_REG: nat_bit = n_reg_bit;
      NSRC_OVH: nat_bit = ovh_data_in;
      NSRC_DL:  nat_bit = dl_n_bit;
      default:  nat_bit = payload_in;
    endcase
  end

  // output selection
  always_comb begin
    ser_out = 1'b0;
    if (run) begin
      case (slot)
        SLOT_ALIGN: ser_out = align_bit;
        SLOT_ALARM: ser_out = alarm_q;
        SLOT_NAT:   ser_out = nat_bit;
        default:    ser_out = payload_in;
      endcase
    end
  end

  assert_align_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (ser_out == PATTERN[PAT_W-2]));

endmodule

// File: rtl/e3_tx_ovh_seq.sv
module e3_tx_ovh_seq
  import e3_ovh_pkg::*;
#(
  parameter int               FRAME_BITS = 1536,
  parameter int               OVH_BITS   = 12,
  parameter int               PAT_W      = 10,
  parameter logic [PAT_W-1:0] PATTERN    = 10'b1111010000,
  parameter int               SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] n_src_sel,
  input  logic       n_reg_bit,
  input  logic       ovh_data_in,
  input  logic       dl_n_bit,
  input  logic       alarm_in,
  input  logic       payload_in,
  output logic       ser_out,
  output logic       ovh_ind,
  output logic       frame_pulse
);

  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] ALARM_IDX = IDX_W'(PAT_W);

  logic             rst_int_n;
  logic             run;
  logic [IDX_W-1:0] idx;
  logic             frame_start;
  logic             ovh_active;
  slot_e            slot;

  e3_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  e3_frame_counter #(
    .FRAME_BITS (FRAME_BITS),
    .OVH_BITS   (OVH_BITS),
    .PAT_W      (PAT_W),
    .IDX_W      (IDX_W)
  ) u_counter (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .run         (run),
    .idx         (idx),
    .frame_start (frame_start),
    .ovh_active  (ovh_active),
    .slot        (slot)
  );

  e3_ovh_mux #(
    .PAT_W   (PAT_W),
    .PATTERN (PATTERN),
    .IDX_W   (IDX_W)
  ) u_mux (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .run         (run),
    .idx         (idx),
    .frame_start (frame_start),
    .slot        (slot),
    .n_src_sel   (n_src_sel),
    .n_reg_bit   (n_reg_bit),
    .ovh_data_in (ovh_data_in),
    .dl_n_bit    (dl_n_bit),
    .alarm_in    (alarm_in),
    .payload_in  (payload_in),
    .ser_out     (ser_out)
  );

  assign ovh_ind     = ovh_active;
  assign frame_pulse = frame_start;

  // alarm slot repeats the level seen in slot 0, PAT_W clocks earlier
  assert_alarm_slot_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run && idx == ALARM_IDX) |-> (ser_out == $past(alarm_in, PAT_W)));

endmodule

// File: tb/test_e3_tx_ovh_seq.sv
module test_e3_tx_ovh_seq;

  localparam int FRAME = 1536;
  localparam logic [9:0] PAT = 10'b1111010000;
  // fields: [6:5] sel, [4] n_reg, [3] ovh_data, [2] dl, [1] payload N, [0] alarm
  localparam logic [6:0] VEC [8] = '{
    7'b00_1_0_0_0_0,
    7'b00_0_1_1_1_1,
    7'b01_0_1_0_0_1,
    7'b01_1_0_1_1_0,
    7'b10_0_0_1_0_0,
    7'b10_1_1_0_1_1,
    7'b11_0_0_0_1_0,
    7'b11_1_1_1_0_1
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] n_src_sel;
  logic       n_reg_bit, ovh_data_in, dl_n_bit, alarm_in, payload_in;
  logic       ser_out, ovh_ind, frame_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  e3_tx_ovh_seq i_e3_tx_ovh_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .n_src_sel   (n_src_sel),
    .n_reg_bit   (n_reg_bit),
    .ovh_data_in (ovh_data_in),
    .dl_n_bit    (dl_n_bit),
    .alarm_in    (alarm_in),
    .payload_in  (payload_in),
    .ser_out     (ser_out),
    .ovh_ind     (ovh_ind),
    .frame_pulse (frame_pulse)
  );

  task automatic chk(input logic act, input logic exp, input string req, input int p);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s slot %0d: actual=%b expected=%b", req, p, act, exp);
    end
  endtask

  function automatic logic pay_val(input int p, input int vi);
    return logic'(p[0] ^ p[3] ^ p[7] ^ vi[0]);
  endfunction

  function automatic logic nat_exp(input logic [6:0] vv);
    case (vv[6:5])
      2'b00:   return vv[4];
      2'b01:   return vv[3];
      2'b10:   return vv[2];
      default: return vv[1];
    endcase
  endfunction

  function automatic logic exp_bit(input logic [6:0] vv, input int p, input int vi);
    if (p < 10)       return PAT[9 - p];
    else if (p == 10) return vv[0];
    else if (p == 11) return nat_exp(vv);
    else              return pay_val(p, vi);
  endfunction

  task automatic drive(input logic [6:0] vv, input int p, input int vi);
    n_src_sel   = vv[6:5];
    n_reg_bit   = (p == 11) ? vv[4] : ~vv[4];
    ovh_data_in = (p == 11) ? vv[3] : ~vv[3];
    dl_n_bit    = (p == 11) ? vv[2] : ~vv[2];
    alarm_in    = (p == 0)  ? vv[0] : ~vv[0];
    if (p >= 12)
      payload_in = pay_val(p, vi);
    else if (p == 11 && vv[6:5] == 2'b11)
      payload_in = vv[1];
    else
      payload_in = ~exp_bit(vv, p, vi);
  endtask

  task automatic check_slot(input logic [6:0] vv, input int p, input int vi);
    string req;
    chk(frame_pulse, logic'(p == 0), "R2", p);
    chk(ovh_ind, logic'(p < 12), "R3", p);
    if (p < 10)       req = "R4";
    else if (p == 10) req = "R5";
    else if (p == 11) begin
      case (vv[6:5])
        2'b00:   req = "R6";
        2'b01:   req = "R7";
        2'b10:   req = "R8";
        default: req = "R9";
      endcase
    end else          req = "R10";
    chk(ser_out, exp_bit(vv, p, vi), req, p);
  endtask

  // release reset and wait for the first frame; R1 start latency
  task automatic release_and_sync(input logic [6:0] vv, input int vi);
    int wait_n = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int w = 1; w <= 6; w++) begin
      @(negedge clk);
      drive(vv, 0, vi);
      #2;
      if (frame_pulse === 1'b1 && wait_n == 0) wait_n = w;
      if (wait_n != 0) break;
    end
    checks++;
    if (wait_n != 3) begin
      errors++;
      $display("FAIL R1 start latency: actual=%0d expected=3", wait_n);
    end
  endtask

  initial begin
    #(150000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    n_src_sel = 2'b11; n_reg_bit = 1'b1; ovh_data_in = 1'b1;
    dl_n_bit = 1'b1; alarm_in = 1'b1; payload_in = 1'b1;
    // R1: outputs quiet in reset
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      #2;
      chk(ser_out, 1'b0, "R1", -1);
      chk(ovh_ind, 1'b0, "R1", -1);
      chk(frame_pulse, 1'b0, "R1", -1);
    end

    release_and_sync(VEC[0], 0);

    // vector table walked one frame per entry
    for (int vi = 0; vi < 8; vi++) begin
      for (int p = 0; p < FRAME; p++) begin
        if (!(vi == 0 && p == 0)) begin
          @(negedge clk);
          drive(VEC[vi], p, vi);
          #2;
        end
        check_slot(VEC[vi], p, vi);
      end
    end

    // directed: reset mid-frame (R1), then restart overhead
    for (int p = 0; p < 300; p++) begin
      @(negedge clk);
      drive(VEC[5], p, 5);
    end
    @(negedge clk);
    rst_n = 1'b0;
    payload_in = 1'b1;
    #2;
    chk(ser_out, 1'b0, "R1", -2);
    chk(ovh_ind, 1'b0, "R1", -2);
    chk(frame_pulse, 1'b0, "R1", -2);
    @(negedge clk);
    @(negedge clk);
    release_and_sync(VEC[3], 3);
    for (int p = 0; p < 16; p++) begin
      if (p != 0) begin
        @(negedge clk);
        drive(VEC[3], p, 3);
        #2;
      end
      check_slot(VEC[3], p, 3);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule